// File: doc/BRIEF.md
# Serial Attenuator Control Register

This block is the control slave of a digital step attenuator. It accepts a three-wire serial stream made of a serial clock, a data line and a latch strobe. All three are sampled by a fast system clock. While the strobe is low, each rising serial clock edge shifts one data bit into an 8-bit shift register, least significant bit first. A rising strobe copies the shift register into a parallel holding register. The holding register drives the 5-bit attenuation setting in dB, and the full word is also available for readback.

Two status flags come from the same latch event. The first reports a word that sets the reserved bit, which must be zero to keep 1 dB steps. The second reports a latch that arrived before a full word had been shifted in. After reset the block selects the largest attenuation, which is the minimum-gain state.

Top module: `atten_serial_ctrl`

## Requirements
- R1: Each rising serial clock edge seen while the strobe is low shifts exactly one data bit into the 8-bit shift register.
- R2: Bits arrive least significant first. After eight shifts, the first bit received sits at word bit 0 and the eighth at word bit 7.
- R3: While the strobe is high, serial clock edges leave the shift register and the bit count unchanged.
- R4: After reset, `word_o` is 0x7C, `atten_db_o` is 31, and `illegal_o` and `short_o` are 0.
- R5: `atten_db_o` equals word bits 6..2 read as an unsigned binary number. Bit 2 weighs 1 dB, bit 3 weighs 2 dB, bit 4 weighs 4 dB, bit 5 weighs 8 dB and bit 6 weighs 16 dB.
- R6: Word bits 0 and 7 have no effect on `atten_db_o`. They still appear unchanged on `word_o`.
- R7: The holding register loads the shift register contents only on a rising strobe, and keeps its value until the next rising strobe.
- R8: `illegal_o` becomes 1 when a latched word has bit 1 set. It keeps that value until a word with bit 1 clear is latched, or until reset.
- R9: At each latch, `short_o` becomes 1 if fewer than 8 bits were shifted since the previous latch, and 0 otherwise. A latch with no shifted bits counts as short. When more than 8 bits are shifted, the register keeps the last 8 received.
- R10: The serial pins pass through a synchronizer and are edge-detected in the system clock domain. The block operates correctly when the system clock is at least 4 times the serial clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Latch strobe, asynchronous, idle high |
| word_o | output | 8 | Latched control word |
| atten_db_o | output | 5 | Attenuation in dB |
| illegal_o | output | 1 | Sticky flag: latched word had bit 1 set |
| short_o | output | 1 | Last latch came after fewer than 8 bits |

## Verification
The bench targets the bit order. A design that shifted most significant bit first would turn 22 dB into a different setting. It checks that serial clocks given while the strobe is high are ignored: a design that shifted anyway would latch a changed word, and would clear the short flag on a relatch with no new bits. It covers partial words and words longer than 8 bits, which catch a counter that fails to saturate or to clear. It also checks the illegal flag stays set until a legal word arrives, and that bits 0 and 7 do not leak into the attenuation value.

// File: rtl/atten_ctrl_pkg.sv
`timescale 1ns/1ps
package atten_ctrl_pkg;
  localparam int unsigned PIN_CLK = 0;
  localparam int unsigned PIN_DAT = 1;
  localparam int unsigned PIN_LE  = 2;
  localparam int unsigned PIN_N   = 3;
  // idle levels of the serial pins: strobe high, clock and data low
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= {STAGES{IDLE[g]}};
        prev_q  <= IDLE[g];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/shift_unit.sv
`timescale 1ns/1ps
module shift_unit #(
  parameter int unsigned W = 8,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  input  logic             clr,
  output logic [W-1:0]     sr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en) sr_q <= {din, sr_q[W-1:1]};
      if (clr) cnt_q <= '0;
      else if (shift_en && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end
  assign sr_o  = sr_q;
  assign cnt_o = cnt_q;

  // R1/R3: without a qualified shift the register keeps its contents
  p_hold_sr_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
  // R9: bit count saturates at the word width
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R1: one shift moves the previous top bit down by one place
  p_one_bit_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sr_q[W-2] == $past(sr_q[W-1]));
endmodule

// File: rtl/latch_unit.sv
`timescale 1ns/1ps
module latch_unit #(
  parameter int unsigned W       = 8,
  parameter int unsigned ATT_LSB = 2,
  parameter int unsigned ATT_W   = 5,
  parameter int unsigned RSV_BIT = 1,
  localparam int unsigned CNT_W  = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     sr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]     word_o,
  output logic [ATT_W-1:0] atten_o,
  output logic             illegal_o,
  output logic             short_o
);
  localparam logic [ATT_W-1:0] ATT_MAX   = '1;
  localparam logic [W-1:0]     RST_WORD  = W'(ATT_MAX) << ATT_LSB;
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(W);

  logic [W-1:0]     word_q;
  logic [ATT_W-1:0] atten_q;
  logic             illegal_q, short_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= RST_WORD;
      atten_q   <= ATT_MAX;
      illegal_q <= 1'b0;
      short_q   <= 1'b0;
    end else if (load) begin
      word_q    <= sr_i;
      atten_q   <= sr_i[ATT_LSB +: ATT_W];
      illegal_q <= sr_i[RSV_BIT];
      short_q   <= (cnt_i != FULL);
    end
  end
  assign word_o    = word_q;
  assign atten_o   = atten_q;
  assign illegal_o = illegal_q;
  assign short_o   = short_q;

  p_reset_state_r4: assert property (@(posedge clk)
    rst |=> word_q == RST_WORD && atten_q == ATT_MAX && !illegal_q && !short_q);
  p_hold_word_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(word_q) && $stable(atten_q) && $stable(illegal_q) && $stable(short_q));
  p_atten_field_r5: assert property (@(posedge clk) disable iff (rst)
    atten_q == word_q[ATT_LSB +: ATT_W]);
  p_illegal_flag_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_q == word_q[RSV_BIT]);
endmodule

// File: rtl/atten_serial_ctrl.sv
`timescale 1ns/1ps
module atten_serial_ctrl
  import atten_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned ATT_LSB     = 2,
  parameter int unsigned ATT_W       = 5,
  parameter int unsigned RSV_BIT     = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [WORD_W-1:0] word_o,
  output logic [ATT_W-1:0]  atten_db_o,
  output logic              illegal_o,
  output logic              short_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [PIN_N-1:0]  pins, lvl, rise;
  logic              shift_en;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  assign pins = {ser_le_i, ser_dat_i, ser_clk_i};

  pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins), .lvl_o(lvl), .rise_o(rise));

  // R3: serial clock edges count only while the strobe is low
  assign shift_en = rise[PIN_CLK] & ~lvl[PIN_LE];

  shift_unit #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(lvl[PIN_DAT]),
    .clr(rise[PIN_LE]), .sr_o(sr), .cnt_o(cnt));

  latch_unit #(.W(WORD_W), .ATT_LSB(ATT_LSB), .ATT_W(ATT_W), .RSV_BIT(RSV_BIT)) u_latch (
    .clk(clk), .rst(rst), .load(rise[PIN_LE]), .sr_i(sr), .cnt_i(cnt),
    .word_o(word_o), .atten_o(atten_db_o), .illegal_o(illegal_o), .short_o(short_o));

  p_le_blocks_clk_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl[PIN_LE] && rise[PIN_CLK]) |=> $stable(sr) && $stable(cnt));
  p_latch_copies_r7: assert property (@(posedge clk) disable iff (rst)
    rise[PIN_LE] |=> word_o == $past(sr));
endmodule

// File: tb/test_atten_serial_ctrl.sv
`timescale 1ns/1ps
module test_atten_serial_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b1;
  logic [7:0] word;
  logic [4:0] atten;
  logic illegal, short_w;

  int checks = 0;
  int errors = 0;

  // model state derived from the requirements
  logic [7:0] m_sr = 8'h00;
  int         m_cnt = 0;
  logic [7:0] m_word = 8'h7C;
  logic       m_short = 1'b0;

  always #4 clk = ~clk;

  atten_serial_ctrl i_atten_serial_ctrl (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
    .word_o(word), .atten_db_o(atten), .illegal_o(illegal), .short_o(short_w));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    wait_cyc(4);
    ser_clk = 1'b0;
    if (!ser_le) begin
      m_sr = {b, m_sr[7:1]};
      if (m_cnt < 8) m_cnt++;
    end
  endtask

  task automatic raise_le();
    ser_le = 1'b1;
    wait_cyc(8);
    m_word  = m_sr;
    m_short = (m_cnt < 8);
    m_cnt   = 0;
  endtask

  // shift nbits of val LSB first, then latch
  task automatic write_bits(input logic [15:0] val, input int nbits);
    ser_le = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < nbits; i++) send_bit(val[i]);
    raise_le();
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " word"},    word,    m_word);
    check({tag, " atten"},   atten,   m_word[6:2]);
    check({tag, " illegal"}, illegal, m_word[1]);
    check({tag, " short"},   short_w, m_short);
  endtask

  task automatic t_reset();
    check("R4 reset word", word, 8'h7C);
    check("R4 reset atten", atten, 31);
    check("R4 reset illegal", illegal, 0);
    check("R4 reset short", short_w, 0);
  endtask

  task automatic t_lsb_first();
    write_bits(16'h0058, 8);
    check("R2 word 22dB", word, 8'h58);
    check("R5 atten 22dB", atten, 22);
    check_outputs("R1");
    write_bits(16'h0000, 8);
    check("R5 atten 0", atten, 0);
    write_bits(16'h007C, 8);
    check("R5 atten 31", atten, 31);
    write_bits(16'h0010, 8);
    check("R5 atten 4", atten, 4);
  endtask

  task automatic t_dont_care();
    write_bits(16'h0081, 8);
    check("R6 word bits0/7", word, 8'h81);
    check("R6 atten unaffected", atten, 0);
    write_bits(16'h00A0, 8);
    check("R6 atten 8 with bit7", atten, 8);
  endtask

  task automatic t_illegal();
    write_bits(16'h0006, 8);
    check("R8 illegal set", illegal, 1);
    check("R8 atten still decoded", atten, 1);
    wait_cyc(20);
    check("R7 hold illegal", illegal, 1);
    check("R7 hold word", word, 8'h06);
    write_bits(16'h0004, 8);
    check("R8 illegal cleared", illegal, 0);
  endtask

  task automatic t_le_high_ignored();
    // strobe high: clocks with data 1 must not shift
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    ser_le = 1'b0;
    wait_cyc(8);
    check("R7 no latch while low", word, 8'h04);
    raise_le();
    check("R3 word unchanged", word, 8'h04);
    check("R3 short after no bits", short_w, 1);
  endtask

  task automatic t_short_long();
    write_bits(16'h0005, 3);
    check_outputs("R9 partial");
    check("R9 short set", short_w, 1);
    write_bits(16'h03F0, 10);
    check_outputs("R9 long");
    check("R9 long word", word, 8'hFC);
    check("R9 short clear", short_w, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(4);
    t_reset();
    t_lsb_first();
    t_dont_care();
    t_illegal();
    t_le_high_ignored();
    t_short_long();
    // R10: all above ran with 4 system clocks per serial half period
    check("R10 final atten", atten, m_word[6:2]);
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(2);
    check("R4 reset again", word, 8'h7C);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule